// File: doc/BRIEF.md
# H-Bridge Switch Protection Controller

This block is the digital control and fault manager for a two-channel H-bridge in which each channel pairs an internal high-side switch with an external low-side transistor. Two direction inputs and a wake input select the bridge state. A set of already-digitised analog flags reports faults: supply low, supply high, die overtemperature, a high-side overcurrent flag per channel, a low-side desaturation flag per channel, and a per-channel comparator that says the output node is below 2 V.

From these inputs the block drives, per channel, a high-side enable, a tri-state request and a low-side gate enable, plus one active-low fault status line. Every input crosses two synchroniser flops, and every output is registered. Each fault class has its own output pattern, its own rule for the status line and its own way back to normal operation. Some faults clear on their own. Others stay latched until the channel's direction input is cycled.

Top module: `hbridge_guard`

## Requirements
- R1: While wake is low, every channel has its high side off, its tri-state request set and its low-side gate off, and the status line is high. This holds whatever the other inputs do, and entering standby clears every latched fault.
- R2: With wake high and no fault, a channel whose direction bit is 1 has its high side on and its low-side gate off. A channel whose direction bit is 0 has its high side off and requests its low-side gate on. Tri-state requests are 0 and status is high. Bit 0 of every per-channel vector is channel 1.
- R3: A low-side gate enable is driven 1 only when that channel's output-below-2V flag, as synchronised, was 1 in the cycle before.
- R4: A high-side overcurrent flag seen while channel n is commanded high latches channel n only. Its high side turns off, its tri-state request is set, its low-side gate is off and status goes low. The other channel keeps following its direction bit.
- R5: A high-side overcurrent latch survives removal of the flag. It clears once the channel's direction bit is 0, and the channel is driven high again on the next 1.
- R6: Overtemperature is not acted on while every high side is off: status stays high and the brake pattern is kept.
- R7: Overtemperature that arrives while a high side is on turns both high sides off and requests both low-side gates on, with status low. It recovers by itself once the flag drops, and the bridge returns to the state the direction bits command.
- R8: A desaturation flag trips only after it has been high for BLANK_CYC consecutive synchronised samples. A shorter run does not trip, and any low sample restarts the count.
- R9: A tripped low-side overload sets both tri-state requests, turns both high sides and both low-side gates off, and drives status low.
- R10: A low-side overload clears only on a 1-to-0 transition of the faulted channel's direction bit. Cycling the other channel's bit has no effect.
- R11: Supply-low or supply-high turns both high sides off and requests both low-side gates on, with status high. The bridge recovers by itself when the flag drops.
- R12: Priority runs from standby, to latched low-side overload, to overtemperature, to supply fault, to the per-channel high-side latch, to normal operation.
- R13: A direction change at the pins reaches the outputs on the third rising clock edge after it is applied, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_i | input | 1 | 1 = operate, 0 = standby |
| dir_i | input | NCH | Direction command per channel |
| uv_i | input | 1 | Supply below lower limit |
| ov_i | input | 1 | Supply above upper limit |
| otemp_i | input | 1 | Die overtemperature comparator |
| hs_oc_i | input | NCH | High-side overcurrent flag per channel |
| ls_desat_i | input | NCH | Low-side desaturation flag per channel |
| out_low_i | input | NCH | Output node below 2 V per channel |
| hs_en_o | output | NCH | High-side switch enable |
| hiz_o | output | NCH | Output tri-state request |
| ls_gate_o | output | NCH | External low-side gate enable |
| fault_n_o | output | 1 | Status, low while a reported fault is present |

## Verification
The hardest state to reach from the ports is the low-side overload latch, together with its recovery rule. The desaturation flag has to be held for exactly the blanking length, because one sample less must leave the bridge untouched. Afterwards only a falling edge of the faulted channel's own input may release the latch. The directed stimulus uses a short blanking parameter and holds the flag for one cycle less, then splits a run with a single low cycle, and only then holds it long enough to trip. Once the latch is set, it cycles the other channel's input first, which must not clear the latch. It then raises and lowers the faulted channel's input, and stacks overtemperature and supply faults on top to test the priority order.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
  typedef enum logic [2:0] {
    MODE_SLEEP  = 3'd0,
    MODE_LSTRIP = 3'd1,
    MODE_HOT    = 3'd2,
    MODE_SUPPLY = 3'd3,
    MODE_RUN    = 3'd4
  } bridge_mode_e;

  typedef struct packed {
    logic hs;
    logic hiz;
    logic ls_req;
  } chan_drive_t;

  function automatic chan_drive_t drive_for(bridge_mode_e m, logic hs_latched, logic dir);
    chan_drive_t d;
    d = '{hs: 1'b0, hiz: 1'b1, ls_req: 1'b0};
    case (m)
      MODE_SLEEP, MODE_LSTRIP: d = '{hs: 1'b0, hiz: 1'b1, ls_req: 1'b0};
      MODE_HOT, MODE_SUPPLY:   d = '{hs: 1'b0, hiz: 1'b0, ls_req: 1'b1};
      default: begin
        if (hs_latched) d = '{hs: 1'b0, hiz: 1'b1, ls_req: 1'b0};
        else if (dir)   d = '{hs: 1'b1, hiz: 1'b0, ls_req: 1'b0};
        else            d = '{hs: 1'b0, hiz: 1'b0, ls_req: 1'b1};
      end
    endcase
    return d;
  endfunction
endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/hbg_blank.sv
module hbg_blank #(
  parameter int CYC = 750
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic flag_i,
  output logic trip_o
);
  localparam int CW = (CYC < 2) ? 1 : $clog2(CYC);
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] cnt;

  assign trip_o = flag_i && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr_i || !flag_i) cnt <= '0;
    else if (cnt == LAST)        cnt <= '0;
    else                         cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/hbg_hs_latch.sv
module hbg_hs_latch (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic set_i,
  output logic lat_o
);
  always_ff @(posedge clk) begin
    if (rst || clr_i) lat_o <= 1'b0;
    else if (set_i)   lat_o <= 1'b1;
  end
endmodule

// File: rtl/hbridge_guard.sv
module hbridge_guard
  import hbg_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int SYNC_STAGES = 2,
  parameter int BLANK_CYC   = 750
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wake_i,
  input  logic [NCH-1:0] dir_i,
  input  logic           uv_i,
  input  logic           ov_i,
  input  logic           otemp_i,
  input  logic [NCH-1:0] hs_oc_i,
  input  logic [NCH-1:0] ls_desat_i,
  input  logic [NCH-1:0] out_low_i,
  output logic [NCH-1:0] hs_en_o,
  output logic [NCH-1:0] hiz_o,
  output logic [NCH-1:0] ls_gate_o,
  output logic           fault_n_o
);
  localparam int SW = 4 + 4 * NCH;

  logic [SW-1:0]  raw_bus, syn_bus;
  logic [NCH-1:0] dir_s, out_low_s, desat_s, hs_oc_s;
  logic           otemp_s, ov_s, uv_s, wake_s;

  assign raw_bus = {wake_i, uv_i, ov_i, otemp_i, hs_oc_i, ls_desat_i, out_low_i, dir_i};

  hbg_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw_bus),
    .q_o (syn_bus)
  );

  assign dir_s     = syn_bus[NCH-1:0];
  assign out_low_s = syn_bus[2*NCH-1:NCH];
  assign desat_s   = syn_bus[3*NCH-1:2*NCH];
  assign hs_oc_s   = syn_bus[4*NCH-1:3*NCH];
  assign otemp_s   = syn_bus[4*NCH];
  assign ov_s      = syn_bus[4*NCH+1];
  assign uv_s      = syn_bus[4*NCH+2];
  assign wake_s    = syn_bus[4*NCH+3];

  logic [NCH-1:0] dir_d, dir_fall, desat_trip, ls_lat, hs_lat;
  logic           ot_act;

  always_ff @(posedge clk) begin
    if (rst) dir_d <= '0;
    else     dir_d <= dir_s;
  end
  assign dir_fall = dir_d & ~dir_s;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    hbg_blank #(.CYC(BLANK_CYC)) u_blank (
      .clk    (clk),
      .rst    (rst),
      .clr_i  (~wake_s),
      .flag_i (desat_s[g]),
      .trip_o (desat_trip[g])
    );

    hbg_hs_latch u_hs_latch (
      .clk   (clk),
      .rst   (rst),
      .clr_i (~wake_s | ~dir_s[g]),
      .set_i (hs_oc_s[g]),
      .lat_o (hs_lat[g])
    );

    always_ff @(posedge clk) begin
      if (rst || !wake_s)     ls_lat[g] <= 1'b0;
      else if (desat_trip[g]) ls_lat[g] <= 1'b1;
      else if (dir_fall[g])   ls_lat[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !wake_s) ot_act <= 1'b0;
    else if (ot_act)    ot_act <= otemp_s;
    else                ot_act <= otemp_s && (|hs_en_o);
  end

  bridge_mode_e mode;
  always_comb begin
    if (!wake_s)            mode = MODE_SLEEP;
    else if (|ls_lat)       mode = MODE_LSTRIP;
    else if (ot_act)        mode = MODE_HOT;
    else if (uv_s || ov_s)  mode = MODE_SUPPLY;
    else                    mode = MODE_RUN;
  end

  logic [NCH-1:0] hs_nx, hiz_nx, ls_nx;
  logic           fault_n_nx;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      chan_drive_t d;
      d = drive_for(mode, hs_lat[c], dir_s[c]);
      hs_nx[c]  = d.hs;
      hiz_nx[c] = d.hiz;
      ls_nx[c]  = d.ls_req & out_low_s[c];
    end
    fault_n_nx = !wake_s || !((|ls_lat) || ot_act || (|hs_lat));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_en_o   <= '0;
      hiz_o     <= '1;
      ls_gate_o <= '0;
      fault_n_o <= 1'b1;
    end else begin
      hs_en_o   <= hs_nx;
      hiz_o     <= hiz_nx;
      ls_gate_o <= ls_nx;
      fault_n_o <= fault_n_nx;
    end
  end
endmodule

// File: rtl/hbg_guard_chk.sv
module hbg_guard_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           wake_s,
  input logic           uv_s,
  input logic           ov_s,
  input logic [NCH-1:0] out_low_s,
  input logic [NCH-1:0] ls_lat,
  input logic [NCH-1:0] hs_lat,
  input logic           ot_act,
  input logic [NCH-1:0] hs_en_o,
  input logic [NCH-1:0] hiz_o,
  input logic [NCH-1:0] ls_gate_o,
  input logic           fault_n_o
);
  assert_standby_R1: assert property (@(posedge clk) disable iff (rst)
    !wake_s |=> (hiz_o == '1 && hs_en_o == '0 && ls_gate_o == '0 && fault_n_o));

  assert_no_shoot_R3: assert property (@(posedge clk) disable iff (rst)
    (ls_gate_o & ~$past(out_low_s)) == '0);

  assert_leg_excl_R2: assert property (@(posedge clk) disable iff (rst)
    (hs_en_o & (ls_gate_o | hiz_o)) == '0);

  assert_ls_trip_R9: assert property (@(posedge clk) disable iff (rst)
    (wake_s && ls_lat != '0) |=> (hiz_o == '1 && hs_en_o == '0 && ls_gate_o == '0 && !fault_n_o));

  assert_hot_R7: assert property (@(posedge clk) disable iff (rst)
    (wake_s && ls_lat == '0 && ot_act) |=> (hs_en_o == '0 && hiz_o == '0 && !fault_n_o));

  assert_supply_R11: assert property (@(posedge clk) disable iff (rst)
    (wake_s && ls_lat == '0 && !ot_act && hs_lat == '0 && (uv_s || ov_s))
      |=> (fault_n_o && hs_en_o == '0 && hiz_o == '0));

  for (genvar g = 0; g < NCH; g++) begin : g_hs
    assert_hs_latch_R4: assert property (@(posedge clk) disable iff (rst)
      (wake_s && ls_lat == '0 && !ot_act && !uv_s && !ov_s && hs_lat[g])
        |=> (hiz_o[g] && !hs_en_o[g] && !ls_gate_o[g] && !fault_n_o));
  end
endmodule

bind hbridge_guard hbg_guard_chk #(.NCH(NCH)) u_guard_chk (
  .clk       (clk),
  .rst       (rst),
  .wake_s    (wake_s),
  .uv_s      (uv_s),
  .ov_s      (ov_s),
  .out_low_s (out_low_s),
  .ls_lat    (ls_lat),
  .hs_lat    (hs_lat),
  .ot_act    (ot_act),
  .hs_en_o   (hs_en_o),
  .hiz_o     (hiz_o),
  .ls_gate_o (ls_gate_o),
  .fault_n_o (fault_n_o)
);

// File: tb/test_hbridge_guard.sv
module test_hbridge_guard;
  localparam int NCH   = 2;
  localparam int BLANK = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wake = 1'b0, uv = 1'b0, ov = 1'b0, otemp = 1'b0;
  logic [NCH-1:0] dir = '0, hs_oc = '0, desat = '0, out_low = '1;
  logic [NCH-1:0] hs_en, hiz, ls_gate;
  logic fault_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hbridge_guard #(.NCH(NCH), .SYNC_STAGES(2), .BLANK_CYC(BLANK)) i_hbridge_guard (
    .clk (clk), .rst (rst), .wake_i (wake), .dir_i (dir), .uv_i (uv), .ov_i (ov),
    .otemp_i (otemp), .hs_oc_i (hs_oc), .ls_desat_i (desat), .out_low_i (out_low),
    .hs_en_o (hs_en), .hiz_o (hiz), .ls_gate_o (ls_gate), .fault_n_o (fault_n)
  );

  function automatic logic [6:0] pk(logic [1:0] h, logic [1:0] z, logic [1:0] l, logic f);
    return {h, z, l, f};
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(string req, logic [6:0] exp);
    logic [6:0] act;
    act = {hs_en, hiz, ls_gate, fault_n};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: {hs,hiz,ls,fault_n} actual=%b expected=%b", req, act, exp);
    end
  endtask

  localparam logic [6:0] STBY  = 7'b00_11_00_1;
  localparam logic [6:0] BRAKE = 7'b00_00_11_1;
  localparam logic [6:0] LSTRP = 7'b00_11_00_0;

  task automatic t_reset_standby();
    expect_out("R1 reset", STBY);
    dir = 2'b11; hs_oc = 2'b11; otemp = 1'b1; tick(6);
    expect_out("R1 standby ignores inputs", STBY);
    dir = 2'b00; hs_oc = 2'b00; otemp = 1'b0;
  endtask

  task automatic t_normal();
    wake = 1'b1; dir = 2'b00; tick(6);
    expect_out("R2 brake", BRAKE);
    dir = 2'b01; tick(6); expect_out("R2 ch1 high", 7'b01_00_10_1);
    dir = 2'b10; tick(6); expect_out("R2 ch2 high", 7'b10_00_01_1);
    dir = 2'b11; tick(6); expect_out("R2 both high", 7'b11_00_00_1);
    dir = 2'b00; tick(6);
  endtask

  task automatic t_latency();
    dir = 2'b01; tick(2);
    expect_out("R13 before third edge", BRAKE);
    tick(1);
    expect_out("R13 at third edge", 7'b01_00_10_1);
    dir = 2'b00; tick(6);
  endtask

  task automatic t_cross();
    out_low = 2'b01; tick(6); expect_out("R3 ch2 gate held off", 7'b00_00_01_1);
    out_low = 2'b00; tick(6); expect_out("R3 both gates held off", 7'b00_00_00_1);
    out_low = 2'b11; tick(6);
  endtask

  task automatic t_hs_oc();
    dir = 2'b11; tick(6);
    hs_oc = 2'b01; tick(6);
    expect_out("R4 ch1 latched only", 7'b10_01_00_0);
    hs_oc = 2'b00; tick(6);
    expect_out("R5 latch survives flag removal", 7'b10_01_00_0);
    dir = 2'b10; tick(6);
    expect_out("R5 cleared by low input", 7'b10_00_01_1);
    dir = 2'b11; tick(6);
    expect_out("R5 re-enabled on rise", 7'b11_00_00_1);
    dir = 2'b00; tick(6);
  endtask

  task automatic t_overtemp();
    otemp = 1'b1; tick(6);
    expect_out("R6 ignored with high sides off", BRAKE);
    otemp = 1'b0; tick(4);
    dir = 2'b01; tick(6);
    otemp = 1'b1; tick(6);
    expect_out("R7 trip", 7'b00_00_11_0);
    otemp = 1'b0; tick(6);
    expect_out("R7 auto recovery", 7'b01_00_10_1);
    dir = 2'b00; tick(6);
  endtask

  task automatic t_blanking();
    desat = 2'b01; tick(BLANK - 1); desat = 2'b00; tick(6);
    expect_out("R8 short run no trip", BRAKE);
    desat = 2'b01; tick(BLANK - 1); desat = 2'b00; tick(1);
    desat = 2'b01; tick(BLANK - 1); desat = 2'b00; tick(6);
    expect_out("R8 interrupted run no trip", BRAKE);
    desat = 2'b01; tick(BLANK); desat = 2'b00; tick(6);
    expect_out("R9 full run trips bridge", LSTRP);
  endtask

  task automatic t_ls_recover();
    dir = 2'b10; tick(6); dir = 2'b00; tick(6);
    expect_out("R10 other channel cycle ignored", LSTRP);
    dir = 2'b01; tick(6);
    expect_out("R10 still latched while high", LSTRP);
    dir = 2'b00; tick(6);
    expect_out("R10 released on falling edge", BRAKE);
  endtask

  task automatic t_supply();
    dir = 2'b01; tick(6);
    uv = 1'b1; tick(6); expect_out("R11 undervoltage", 7'b00_00_11_1);
    uv = 1'b0; tick(6); expect_out("R11 uv recovery", 7'b01_00_10_1);
    ov = 1'b1; tick(6); expect_out("R11 overvoltage", 7'b00_00_11_1);
    ov = 1'b0; tick(6); expect_out("R11 ov recovery", 7'b01_00_10_1);
  endtask

  task automatic t_priority();
    otemp = 1'b1; tick(6);
    ov = 1'b1; tick(6);
    expect_out("R12 overtemp above supply", 7'b00_00_11_0);
    desat = 2'b10; tick(BLANK + 2); desat = 2'b00; tick(6);
    expect_out("R12 ls overload above overtemp", LSTRP);
    otemp = 1'b0; ov = 1'b0;
    dir = 2'b11; tick(6); dir = 2'b01; tick(6);
    expect_out("R12 R10 recovery to commanded state", 7'b01_00_10_1);
    wake = 1'b0; tick(6);
    expect_out("R1 back to standby", STBY);
  endtask

  initial begin
    tick(5);
    rst = 1'b0;
    tick(1);
    t_reset_standby();
    t_normal();
    t_latency();
    t_cross();
    t_hs_oc();
    t_overtemp();
    t_blanking();
    t_ls_recover();
    t_supply();
    t_priority();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule